// File: doc/BRIEF.md
# Video Sync Pulse Generator

The block turns two per-line strobes into the horizontal sync pulse and the field or vertical sync signal that a video encoder needs. All timing is counted in pixel clocks. A line-start strobe begins a new line. It drives HSYNC low at once. When the same strobe also carries a field-step flag, the block schedules a field edge at a programmed distance behind the HSYNC leading edge. The block does not count lines or fields: whatever sequences the raster decides which lines carry the field-step flag.

One 8-bit control byte sets the timing through 2-bit codes. The HSYNC and VSYNC pulse widths come from a table of 1/4/16/128 clocks. The HSYNC-to-field distance comes from a table of 0/4/8/16 clocks. A pixel alignment delay of 0 to 3 clocks is applied to a pass-through pixel bus.

In field-level mode the field output is a level that toggles at each scheduled edge. One control bit in this mode can push the edge back by a further half line, and a parameter sets the half-line length in clocks. In VSYNC mode the scheduled edge starts an active-low pulse of programmable width, and the half-line bit has no effect. The control byte and the mode are sampled only when a line start is accepted.

Top module: `vsg_sync_gen`

## Requirements
- R1: After reset, hsync_n_o is 1, fv_o is 0 (field-level mode with field level 0) and pix_o is 0.
- R2: An accepted line start drives hsync_n_o low from the next clock edge for W clocks, where ctrl_i[1:0] = 00, 01, 10, 11 gives W = 1, 4, 16, 128.
- R3: A line start that arrives while hsync_n_o is low is ignored. The running pulse is not restarted, and neither its control byte nor its field-step flag is taken.
- R4: A line start with field_step_i = 1 places the field edge D clocks after the HSYNC leading edge, where ctrl_i[3:2] = 00, 01, 10, 11 gives D = 0, 4, 8, 16.
- R5: With mode_i = 0 (field-level mode), fv_o toggles at the field edge. If ctrl_i[4] = 1, HALF_LINE clocks are added to D (default 864).
- R6: With mode_i = 1 (VSYNC mode), fv_o is an active-low VSYNC pulse that starts at the field edge and lasts 1, 4, 16 or 128 clocks for ctrl_i[5:4] = 00, 01, 10, 11. In this mode ctrl_i[4] adds no half-line offset.
- R7: pix_o equals pix_i delayed by 1 + P clocks, where P = ctrl_i[7:6] taken at the last accepted line start.
- R8: ctrl_i and mode_i are sampled only when a line start is accepted. Changing them at any other time does not alter a pulse in progress or the pixel delay.
- R9: A line start with field_step_i = 0 leaves the field output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_start_i | input | 1 | One-clock strobe that begins a line |
| field_step_i | input | 1 | Qualifies line_start_i: schedule a field edge on this line |
| mode_i | input | 1 | 0 = field-level output, 1 = VSYNC pulse output |
| ctrl_i | input | 8 | Timing control byte (fields as in R2 and R4 to R7) |
| pix_i | input | PIX_W | Pixel data in |
| hsync_n_o | output | 1 | Horizontal sync, active low |
| fv_o | output | 1 | Field level (mode 0) or VSYNC, active low (mode 1) |
| pix_o | output | PIX_W | Pixel data after the alignment delay |

## Verification
The assertions assume three things about the inputs. line_start_i is a single-clock strobe. field_step_i has meaning only while line_start_i is high. The mode and control byte stay in their valid encodings, and every 2-bit code is legal. The stimulus keeps within these rules. It raises each strobe for exactly one clock and lets every line run until HSYNC and any VSYNC or pending field edge have finished before the next line starts. The one exception is the deliberate busy-line case, and even there the injected strobe lasts a single clock. After each strobe the stimulus drives a different, inverted control byte, so that control changes outside accepted line starts are exercised.

// File: rtl/vsg_pkg.sv
package vsg_pkg;

    typedef enum logic {
        MODE_FIELD = 1'b0,
        MODE_VSYNC = 1'b1
    } vsg_mode_e;

    localparam int unsigned CTRL_W    = 8;
    localparam int unsigned MAX_SKEW  = 3;
    localparam int unsigned MAX_WIDTH = 128;
    localparam int unsigned MAX_DELAY = 16;

    // nonlinear width table shared by HSYNC and VSYNC
    function automatic int unsigned width_clocks(input logic [1:0] code);
        case (code)
            2'b00:   return 1;
            2'b01:   return 4;
            2'b10:   return 16;
            default: return 128;
        endcase
    endfunction

    // HSYNC leading edge to field edge distance
    function automatic int unsigned delay_clocks(input logic [1:0] code);
        case (code)
            2'b00:   return 0;
            2'b01:   return 4;
            2'b10:   return 8;
            default: return 16;
        endcase
    endfunction

endpackage

// File: rtl/vsg_pulse.sv
module vsg_pulse #(
    parameter int unsigned CW = 10
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          start_i,
    input  logic [CW-1:0] width_i,
    output logic          active_o
);

    typedef struct packed {
        logic          act;
        logic [CW-1:0] cnt;
    } pulse_t;

    pulse_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start_i && !st_q.act) begin
            st_d.act = 1'b1;
            st_d.cnt = width_i - CW'(1);
        end else if (st_q.act) begin
            if (st_q.cnt == '0) st_d.act = 1'b0;
            else                st_d.cnt = st_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign active_o = st_q.act;

    AST_PULSE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.act && st_q.cnt != '0) |=> st_q.act); // R8

    AST_PULSE_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.act && st_q.cnt == '0 && !start_i) |=> !st_q.act); // R2

endmodule

// File: rtl/vsg_edge_delay.sv
module vsg_edge_delay #(
    parameter int unsigned CW = 10
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          start_i,
    input  logic [CW-1:0] delay_i,
    output logic          fire_o
);

    typedef struct packed {
        logic          pend;
        logic [CW-1:0] cnt;
    } dly_t;

    dly_t st_d, st_q;

    assign fire_o = (start_i && delay_i == '0) || (st_q.pend && st_q.cnt == '0);

    always_comb begin
        st_d = st_q;
        if (start_i && delay_i != '0) begin
            st_d.pend = 1'b1;
            st_d.cnt  = delay_i - CW'(1);
        end else if (st_q.pend) begin
            if (st_q.cnt == '0) st_d.pend = 1'b0;
            else                st_d.cnt  = st_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    AST_DLY_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fire_o && !start_i) |=> !st_q.pend); // R4

endmodule

// File: rtl/vsg_pix_align.sv
module vsg_pix_align #(
    parameter int unsigned PIX_W = 8,
    parameter int unsigned DEPTH = 3
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic [$clog2(DEPTH+1)-1:0] skew_i,
    input  logic [PIX_W-1:0]           pix_i,
    output logic [PIX_W-1:0]           pix_o
);

    localparam int unsigned SW = $clog2(DEPTH + 1);

    logic [PIX_W-1:0] sr_d [DEPTH];
    logic [PIX_W-1:0] sr_q [DEPTH];
    logic [PIX_W-1:0] pix_d, pix_q;

    for (genvar g = 0; g < DEPTH; g++) begin : g_tap
        if (g == 0) begin : g_first
            assign sr_d[g] = pix_i;
        end else begin : g_next
            assign sr_d[g] = sr_q[g-1];
        end
    end

    always_comb begin
        pix_d = pix_i;
        for (int i = 1; i <= DEPTH; i++) begin
            if (skew_i == SW'(i)) pix_d = sr_q[i-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < DEPTH; i++) sr_q[i] <= '0;
            pix_q <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) sr_q[i] <= sr_d[i];
            pix_q <= pix_d;
        end
    end

    assign pix_o = pix_q;

    AST_PIX_DIRECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (skew_i == '0) |=> (pix_o == $past(pix_i))); // R7

endmodule

// File: rtl/vsg_sync_gen.sv
module vsg_sync_gen
    import vsg_pkg::*;
#(
    parameter int unsigned PIX_W     = 8,
    parameter int unsigned HALF_LINE = 864
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             line_start_i,
    input  logic             field_step_i,
    input  logic             mode_i,
    input  logic [7:0]       ctrl_i,
    input  logic [PIX_W-1:0] pix_i,
    output logic             hsync_n_o,
    output logic             fv_o,
    output logic [PIX_W-1:0] pix_o
);

    localparam int unsigned CW = $clog2(HALF_LINE + MAX_DELAY + MAX_WIDTH + 1);
    localparam int unsigned SW = $clog2(MAX_SKEW + 1);

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        vsg_mode_e         mode;
        logic              field;
    } top_t;

    top_t st_d, st_q;

    logic              hs_act, vs_act, fire, accept, vs_start;
    logic [CW-1:0]     hs_w, vs_w, edge_dly;
    logic [CTRL_W-1:0] ctrl_now;
    vsg_mode_e         mode_now;

    assign accept   = line_start_i && !hs_act;
    assign ctrl_now = accept ? ctrl_i : st_q.ctrl;
    assign mode_now = accept ? vsg_mode_e'(mode_i) : st_q.mode;

    assign hs_w     = CW'(width_clocks(ctrl_i[1:0]));
    assign edge_dly = CW'(delay_clocks(ctrl_i[3:2]))
                    + ((mode_i == MODE_FIELD && ctrl_i[4]) ? CW'(HALF_LINE) : CW'(0));
    assign vs_w     = CW'(width_clocks(ctrl_now[5:4]));
    assign vs_start = fire && (mode_now == MODE_VSYNC);

    vsg_pulse #(.CW(CW)) u_hs (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .start_i  (accept),
        .width_i  (hs_w),
        .active_o (hs_act)
    );

    vsg_edge_delay #(.CW(CW)) u_dly (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (accept && field_step_i),
        .delay_i (edge_dly),
        .fire_o  (fire)
    );

    vsg_pulse #(.CW(CW)) u_vs (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .start_i  (vs_start),
        .width_i  (vs_w),
        .active_o (vs_act)
    );

    vsg_pix_align #(.PIX_W(PIX_W), .DEPTH(MAX_SKEW)) u_pix (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .skew_i (st_q.ctrl[7:6]),
        .pix_i  (pix_i),
        .pix_o  (pix_o)
    );

    always_comb begin
        st_d = st_q;
        if (accept) begin
            st_d.ctrl = ctrl_i;
            st_d.mode = vsg_mode_e'(mode_i);
        end
        if (fire && mode_now == MODE_FIELD) st_d.field = !st_q.field;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.ctrl  <= '0;
            st_q.mode  <= MODE_FIELD;
            st_q.field <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hsync_n_o = !hs_act;
    assign fv_o      = (st_q.mode == MODE_VSYNC) ? !vs_act : st_q.field;

    AST_HS_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (line_start_i && hsync_n_o) |=> !hsync_n_o); // R2

    AST_BUSY_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (line_start_i && !hsync_n_o) |=> $stable(st_q.ctrl)); // R3

    AST_FIELD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !fire |=> $stable(st_q.field)); // R9

    AST_VS_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(vs_act) |-> (st_q.mode == MODE_VSYNC)); // R6

endmodule

// File: tb/vsg_sync_gen_tb.sv
module vsg_sync_gen_tb;

    localparam int PIX_W = 8;
    localparam int WIN   = 1100;
    localparam int NVEC  = 11;

    // {ctrl, mode, field_step, hsync width, first field change t, vsync low count}
    localparam logic [36:0] VEC [NVEC] = '{
        {8'h00, 1'b0, 1'b1, 8'd1,   11'd1,   8'd0},
        {8'h05, 1'b0, 1'b1, 8'd4,   11'd5,   8'd0},
        {8'h0A, 1'b0, 1'b1, 8'd16,  11'd9,   8'd0},
        {8'h0F, 1'b0, 1'b1, 8'd128, 11'd17,  8'd0},
        {8'h1D, 1'b0, 1'b1, 8'd4,   11'd881, 8'd0},
        {8'h01, 1'b0, 1'b0, 8'd4,   11'd0,   8'd0},
        {8'h00, 1'b1, 1'b0, 8'd1,   11'd0,   8'd0},
        {8'h00, 1'b1, 1'b1, 8'd1,   11'd1,   8'd1},
        {8'h15, 1'b1, 1'b1, 8'd4,   11'd5,   8'd4},
        {8'h3B, 1'b1, 1'b1, 8'd128, 11'd9,   8'd128},
        {8'h2E, 1'b1, 1'b1, 8'd16,  11'd17,  8'd16}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             line_start = 1'b0;
    logic             tog = 1'b0;
    logic             mode = 1'b0;
    logic [7:0]       ctrl = 8'h00;
    logic [PIX_W-1:0] pix_in = '0;
    logic             hsync_n, fv;
    logic [PIX_W-1:0] pix_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    vsg_sync_gen #(.PIX_W(PIX_W), .HALF_LINE(864)) u_dut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .line_start_i (line_start),
        .field_step_i (tog),
        .mode_i       (mode),
        .ctrl_i       (ctrl),
        .pix_i        (pix_in),
        .hsync_n_o    (hsync_n),
        .fv_o         (fv),
        .pix_o        (pix_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // strobe one line, then drive an inverted control byte (R8) and observe WIN samples
    task automatic run_line(input logic [7:0] c, input logic m, input logic tg,
                            input int inj_at, input logic [7:0] inj_c,
                            output int w, output int tchg, output int vz);
        logic base;
        w = 0; tchg = 0; vz = 0;
        @(negedge clk);
        base = fv;
        line_start = 1'b1; ctrl = c; mode = m; tog = tg;
        @(negedge clk);
        line_start = 1'b0; tog = 1'b0; ctrl = ~c;
        for (int t = 1; t <= WIN; t++) begin
            if (t > 1) @(negedge clk);
            if (!hsync_n) w++;
            if (m == 1'b0) begin
                if (fv != base && tchg == 0) tchg = t;
            end else if (!fv) begin
                vz++;
                if (tchg == 0) tchg = t;
            end
            if (inj_at != 0 && t == inj_at) begin
                line_start = 1'b1; ctrl = inj_c; tog = 1'b1;
            end else if (inj_at != 0 && t == inj_at + 1) begin
                line_start = 1'b0; tog = 1'b0; ctrl = ~c;
            end
        end
    endtask

    task automatic check_skew(input int p, input string req);
        int bad = 0;
        int got = 0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (k > p && pix_out !== PIX_W'(8'h40 + k - 1 - p)) begin
                bad++;
                got = int'(pix_out);
            end
            pix_in = PIX_W'(8'h40 + k);
        end
        chk(bad == 0, req, got, p);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int w, tc, vz;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(hsync_n === 1'b1, "R1 hsync", int'(hsync_n), 1);
        chk(fv === 1'b0, "R1 fv", int'(fv), 0);
        chk(pix_out === '0, "R1 pix", int'(pix_out), 0);

        // R7 and R8: skew from accepted byte, inverted byte after the strobe has no effect
        for (int p = 0; p < 4; p++) begin
            run_line(8'(p << 6), 1'b0, 1'b0, 0, 8'h00, w, tc, vz);
            chk(w == 1, "R2 width code 00", w, 1);
            chk(tc == 0, "R9 no field step", tc, 0);
            check_skew(p, "R7 R8 pixel skew");
        end

        // R3: busy line start with other byte and field step is ignored
        run_line(8'h0F, 1'b0, 1'b0, 10, 8'hC0, w, tc, vz);
        chk(w == 128, "R3 pulse not restarted", w, 128);
        chk(tc == 0, "R3 field step ignored", tc, 0);
        check_skew(0, "R3 byte not taken");

        // table walk: R2 R4 R5 R6 R8 R9
        for (int i = 0; i < NVEC; i++) begin
            logic [7:0] c;
            logic       m, tg;
            int         ew, et, ev;
            c  = VEC[i][36:29];
            m  = VEC[i][28];
            tg = VEC[i][27];
            ew = int'(VEC[i][26:19]);
            et = int'(VEC[i][18:8]);
            ev = int'(VEC[i][7:0]);
            run_line(c, m, tg, 0, 8'h00, w, tc, vz);
            chk(w == ew, "R2 R8 hsync width", w, ew);
            chk(tc == et, (m ? "R4 R6 vsync start" : "R4 R5 R9 field edge"), tc, et);
            if (m) chk(vz == ev, "R6 vsync width", vz, ev);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule